// File: doc/BRIEF.md
# SDRAM Low-Power Entry Controller

This block decides when an attached SDRAM is put into a low-power state and when it is brought back. It watches two activity signals from the access engine: a request line for a pending access and a busy line for a transfer in flight. Once the bus has been idle for a selectable time, it issues the entry command for the chosen low-power flavour. It then drives the clock-enable pin (CKE) and the gate on the SDRAM clock to match that flavour.

A 2-bit mode input selects the flavour: off, self-refresh, power-down or deep power-down. A 2-bit timeout input selects the idle time before entry. When the device is asleep in self-refresh or power-down and an access arrives, the block issues an exit command. It then holds the access on a wait line until the exit delay has run out. Deep power-down is not woken by accesses. It is left only through a reinitialisation strobe, given after the mode has been moved away from deep power-down. Normal read/write sequencing and periodic refresh belong to other blocks.

Top module: `sdram_lp_ctrl`

## Requirements
- R1: A cycle is idle when `acc_req`=0 and `xfer_busy`=0. Any non-idle cycle restarts the idle count from zero, so entry needs a fresh run of idle cycles.
- R2: With `idle_sel`=0, the entry command is registered at the clock edge that closes the first idle cycle. With `idle_sel`=1, it is registered at the edge that closes the 65th consecutive idle cycle. With `idle_sel`=2 or 3, it is registered at the edge that closes the 129th.
- R3: `lp_mode` encoding: 0 off, 1 self-refresh, 2 power-down, 3 deep power-down. With mode 0, no entry command is ever issued and `sd_cke` stays 1.
- R4: Self-refresh entry puts `lp_cmd`=1 for one cycle, `sd_cke`=0 and `sd_clk_en`=0. Whenever the SDRAM clock is gated, CKE is low.
- R5: Power-down entry puts `lp_cmd`=2 for one cycle, `sd_cke`=0 and keeps `sd_clk_en`=1.
- R6: In self-refresh or power-down, `acc_req`=1 makes the next edge register `lp_cmd`=4 (exit), `sd_cke`=1 and `sd_clk_en`=1. After that the block stays in a wake phase for `exit_dly`+1 cycles (self-refresh) or `PD_EXIT_CYC`+1 cycles (power-down) before it is active again. `acc_wait` is 1 whenever `acc_req`=1 and the block is not active.
- R7: Deep power-down entry (`lp_cmd`=3, `sd_cke`=0, `sd_clk_en`=0) happens only when `lpsdram_en`=1. Mode 3 with `lpsdram_en`=0 behaves as mode 0.
- R8: An access does not wake deep power-down: `acc_wait` stays 1 and CKE stays low. Only `reinit`=1 while `lp_mode`≠3 leaves it. That registers `lp_cmd`=4, `sd_cke`=1 and `sd_clk_en`=1, and the block is active at once.
- R9: While `rst`=1 and after it: `sd_cke`=1, `sd_clk_en`=1, `lp_cmd`=0, `acc_wait`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_mode | input | 2 | Low-power flavour select |
| idle_sel | input | 2 | Idle timeout select |
| lpsdram_en | input | 1 | Attached device is low-power SDRAM |
| exit_dly | input | XSR_W | Self-refresh exit delay in cycles |
| acc_req | input | 1 | Access pending from the access engine |
| xfer_busy | input | 1 | Transfer in progress |
| reinit | input | 1 | Reinitialisation strobe, ends deep power-down |
| sd_cke | output | 1 | SDRAM clock-enable pin |
| sd_clk_en | output | 1 | Gate for the SDRAM clock |
| lp_cmd | output | 3 | Command this cycle: 0 none, 1 self-refresh, 2 power-down, 3 deep power-down, 4 exit |
| acc_wait | output | 1 | Holds the pending access |

## Verification
The hardest situation to reach from the ports is a long timeout that is cut short. An activity cycle lands deep inside a 64-cycle idle window, and the bench must show that the count restarts rather than carrying on. Directed sequences reach this: a busy pulse is placed after 40 idle cycles, and CKE is checked exactly at the 64th and 65th idle edges of the following run. A seeded random phase then drives short idle gaps with the immediate timeout. Requests arrive during both wake phases and both sleep states with varying exit delays, and a bench model tracks the expected CKE, clock gate and wait line every cycle.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  typedef enum logic [2:0] {
    ST_ACT  = 3'd0,
    ST_SREF = 3'd1,
    ST_PDN  = 3'd2,
    ST_DPD  = 3'd3,
    ST_WAKE = 3'd4
  } lpc_state_e;

  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_SREF = 3'd1,
    CMD_PDN  = 3'd2,
    CMD_DPD  = 3'd3,
    CMD_EXIT = 3'd4
  } lpc_cmd_e;

  localparam logic [1:0] LPM_OFF  = 2'd0;
  localparam logic [1:0] LPM_SREF = 2'd1;
  localparam logic [1:0] LPM_PDN  = 2'd2;
  localparam logic [1:0] LPM_DPD  = 2'd3;
endpackage

// File: rtl/lpc_idle_timer.sv
module lpc_idle_timer #(
  parameter int SHORT_CYC = 64,
  parameter int LONG_CYC  = 128
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       idle,
  input  logic [1:0] sel,
  output logic       hit
);
  localparam int CW = $clog2(LONG_CYC + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  always_comb begin
    case (sel)
      2'd0:    limit = '0;
      2'd1:    limit = CW'(SHORT_CYC);
      default: limit = CW'(LONG_CYC);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !run || !idle) cnt <= '0;
    else if (cnt < CW'(LONG_CYC)) cnt <= cnt + 1'b1;
  end

  assign hit = run && idle && (cnt >= limit);

  // R1: activity restarts the idle count
  a_r1_count_restarts: assert property (@(posedge clk) disable iff (rst)
    !idle |=> (cnt == '0));
endmodule

// File: rtl/lpc_wake_timer.sv
module lpc_wake_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (load) cnt <= val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  // R6: the wake countdown only moves downward unless reloaded
  a_r6_countdown_monotonic: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt < $past(cnt)));
endmodule

// File: rtl/sdram_lp_ctrl.sv
module sdram_lp_ctrl
  import lpc_pkg::*;
#(
  parameter int IDLE_SHORT  = 64,
  parameter int IDLE_LONG   = 128,
  parameter int XSR_W       = 4,
  parameter int PD_EXIT_CYC = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       lp_mode,
  input  logic [1:0]       idle_sel,
  input  logic             lpsdram_en,
  input  logic [XSR_W-1:0] exit_dly,
  input  logic             acc_req,
  input  logic             xfer_busy,
  input  logic             reinit,
  output logic             sd_cke,
  output logic             sd_clk_en,
  output logic [2:0]       lp_cmd,
  output logic             acc_wait
);
  localparam int PDW = $clog2(PD_EXIT_CYC + 1);
  localparam int WW  = (PDW > XSR_W) ? PDW : XSR_W;

  lpc_state_e    state, state_n;
  lpc_cmd_e      cmd_q, cmd_n;
  logic          idle, idle_hit, wake_load, wake_done;
  logic [WW-1:0] wake_val;

  assign idle = !acc_req && !xfer_busy;

  lpc_idle_timer #(.SHORT_CYC(IDLE_SHORT), .LONG_CYC(IDLE_LONG)) u_idle (
    .clk (clk),
    .rst (rst),
    .run (state == ST_ACT),
    .idle(idle),
    .sel (idle_sel),
    .hit (idle_hit)
  );

  lpc_wake_timer #(.W(WW)) u_wake (
    .clk (clk),
    .rst (rst),
    .load(wake_load),
    .val (wake_val),
    .done(wake_done)
  );

  always_comb begin
    state_n   = state;
    cmd_n     = CMD_NONE;
    wake_load = 1'b0;
    wake_val  = '0;
    case (state)
      ST_ACT: begin
        if (idle_hit) begin
          case (lp_mode)
            LPM_SREF: begin state_n = ST_SREF; cmd_n = CMD_SREF; end
            LPM_PDN:  begin state_n = ST_PDN;  cmd_n = CMD_PDN;  end
            LPM_DPD: begin
              if (lpsdram_en) begin state_n = ST_DPD; cmd_n = CMD_DPD; end
            end
            default: ;
          endcase
        end
      end
      ST_SREF: begin
        if (acc_req) begin
          state_n = ST_WAKE; cmd_n = CMD_EXIT;
          wake_load = 1'b1; wake_val = WW'(exit_dly);
        end
      end
      ST_PDN: begin
        if (acc_req) begin
          state_n = ST_WAKE; cmd_n = CMD_EXIT;
          wake_load = 1'b1; wake_val = WW'(PD_EXIT_CYC);
        end
      end
      ST_DPD: begin
        if (reinit && lp_mode != LPM_DPD) begin
          state_n = ST_ACT; cmd_n = CMD_EXIT;
        end
      end
      ST_WAKE: begin
        if (wake_done) state_n = ST_ACT;
      end
      default: state_n = ST_ACT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_ACT;
      cmd_q <= CMD_NONE;
    end else begin
      state <= state_n;
      cmd_q <= cmd_n;
    end
  end

  assign sd_cke    = (state == ST_ACT) || (state == ST_WAKE);
  assign sd_clk_en = (state != ST_SREF) && (state != ST_DPD);
  assign lp_cmd    = cmd_q;
  assign acc_wait  = acc_req && (state != ST_ACT);

  // R1: sleep entry only follows an idle cycle
  a_r1_entry_after_idle: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_SREF || cmd_q == CMD_PDN) |-> $past(!acc_req && !xfer_busy));
  // R3: mode off never produces an entry command
  a_r3_off_no_entry: assert property (@(posedge clk) disable iff (rst)
    ($past(lp_mode) == LPM_OFF) |-> !(cmd_q inside {CMD_SREF, CMD_PDN, CMD_DPD}));
  // R4: a gated SDRAM clock always comes with CKE low
  a_r4_gate_implies_cke_low: assert property (@(posedge clk) disable iff (rst)
    !sd_clk_en |-> !sd_cke);
  // R6: CKE returns high only together with an exit command
  a_r6_cke_rise_with_exit: assert property (@(posedge clk) disable iff (rst)
    $rose(sd_cke) |-> (cmd_q == CMD_EXIT));
  // R7: deep power-down needs a low-power device
  a_r7_deep_needs_lp: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_DPD) |-> $past(lpsdram_en));
  // R8: deep power-down holds without a reinit strobe
  a_r8_deep_sticky: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DPD && !reinit) |=> (state == ST_DPD));
endmodule

// File: tb/test_sdram_lp_ctrl.sv
module test_sdram_lp_ctrl;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] lp_mode, idle_sel;
  logic       lpsdram_en, acc_req, xfer_busy, reinit;
  logic [3:0] exit_dly;
  logic       sd_cke, sd_clk_en, acc_wait;
  logic [2:0] lp_cmd;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  sdram_lp_ctrl i_sdram_lp_ctrl (
    .clk(clk), .rst(rst), .lp_mode(lp_mode), .idle_sel(idle_sel),
    .lpsdram_en(lpsdram_en), .exit_dly(exit_dly), .acc_req(acc_req),
    .xfer_busy(xfer_busy), .reinit(reinit), .sd_cke(sd_cke),
    .sd_clk_en(sd_clk_en), .lp_cmd(lp_cmd), .acc_wait(acc_wait)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // bring the block back to its active state with the bus busy
  task automatic go_active();
    acc_req = 1'b1;
    for (int i = 0; i < 40 && (acc_wait || !sd_cke); i++) tick();
    xfer_busy = 1'b1;
    acc_req = 1'b0;
    tick();
  endtask

  // expected entry command for a mode (self-refresh 1, power-down 2)
  function automatic int entry_code(logic [1:0] m);
    return (m == 2'd1) ? 1 : (m == 2'd2) ? 2 : 0;
  endfunction

  task automatic timeout_case(string req, logic [1:0] sel, int n);
    go_active();
    lp_mode = 2'd2; idle_sel = sel; xfer_busy = 1'b0;
    repeat (n) tick();
    chk(req, "cke before timeout", sd_cke, 1);
    tick();
    chk(req, "entry cmd at timeout", lp_cmd, 2);
    chk(req, "cke at timeout", sd_cke, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; lp_mode = 2'd0; idle_sel = 2'd0; lpsdram_en = 1'b0;
    acc_req = 1'b0; xfer_busy = 1'b0; reinit = 1'b0; exit_dly = 4'd0;
    repeat (3) tick();
    chk("R9", "cke in reset", sd_cke, 1);
    chk("R9", "clk_en in reset", sd_clk_en, 1);
    chk("R9", "cmd in reset", lp_cmd, 0);
    chk("R9", "wait in reset", acc_wait, 0);
    rst = 1'b0;
    tick();
    chk("R9", "cmd after reset", lp_cmd, 0);

    // R3: mode off never sleeps
    repeat (10) tick();
    chk("R3", "cke with mode off", sd_cke, 1);
    chk("R3", "cmd with mode off", lp_cmd, 0);

    // R4: self-refresh entry, immediate timeout
    xfer_busy = 1'b1; tick();
    lp_mode = 2'd1; xfer_busy = 1'b0;
    tick();
    chk("R4", "sref cmd", lp_cmd, 1);
    chk("R4", "sref cke", sd_cke, 0);
    chk("R4", "sref clk gate", sd_clk_en, 0);
    tick();
    chk("R4", "cmd is a pulse", lp_cmd, 0);

    // R6: self-refresh exit with delay 3
    exit_dly = 4'd3; acc_req = 1'b1; #1;
    chk("R6", "wait while asleep", acc_wait, 1);
    tick();
    chk("R6", "exit cmd", lp_cmd, 4);
    chk("R6", "cke after exit", sd_cke, 1);
    chk("R6", "clk after exit", sd_clk_en, 1);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R6", "wait during sref wake", acc_wait, 1);
    end
    tick();
    chk("R6", "wait released after sref wake", acc_wait, 0);
    acc_req = 1'b0; xfer_busy = 1'b1; tick();
    xfer_busy = 1'b0; tick();
    chk("R6", "re-entry after access", lp_cmd, 1);

    // R5: power-down
    go_active();
    lp_mode = 2'd2; xfer_busy = 1'b0;
    tick();
    chk("R5", "pdn cmd", lp_cmd, 2);
    chk("R5", "pdn cke", sd_cke, 0);
    chk("R5", "pdn clock runs", sd_clk_en, 1);
    acc_req = 1'b1; tick();
    chk("R6", "pdn exit cmd", lp_cmd, 4);
    tick();
    chk("R6", "wait during pdn wake", acc_wait, 1);
    tick();
    chk("R6", "wait released after pdn wake", acc_wait, 0);

    // R2: timeouts
    timeout_case("R2", 2'd1, 64);
    timeout_case("R2", 2'd2, 128);
    timeout_case("R2", 2'd3, 128);

    // R1: activity in the middle of the window restarts the count
    go_active();
    lp_mode = 2'd2; idle_sel = 2'd1; xfer_busy = 1'b0;
    repeat (40) tick();
    xfer_busy = 1'b1; tick();
    xfer_busy = 1'b0;
    repeat (64) tick();
    chk("R1", "no entry after restart", sd_cke, 1);
    tick();
    chk("R1", "entry after fresh window", lp_cmd, 2);

    // R7: deep power-down gated by device type
    go_active();
    idle_sel = 2'd0; lp_mode = 2'd3; lpsdram_en = 1'b0; xfer_busy = 1'b0;
    repeat (5) tick();
    chk("R7", "no deep without lp device", sd_cke, 1);
    lpsdram_en = 1'b1; tick();
    chk("R7", "deep cmd", lp_cmd, 3);
    chk("R7", "deep cke", sd_cke, 0);
    chk("R7", "deep clk gate", sd_clk_en, 0);

    // R8: accesses do not wake deep power-down
    acc_req = 1'b1;
    repeat (6) tick();
    chk("R8", "deep cke held", sd_cke, 0);
    chk("R8", "deep wait held", acc_wait, 1);
    reinit = 1'b1; tick();
    chk("R8", "reinit with mode 3 ignored", sd_cke, 0);
    lp_mode = 2'd0; tick();
    reinit = 1'b0;
    chk("R8", "deep exit cmd", lp_cmd, 4);
    chk("R8", "deep exit cke", sd_cke, 1);
    chk("R8", "deep exit clk", sd_clk_en, 1);
    chk("R8", "active at once", acc_wait, 0);
    acc_req = 1'b0; lpsdram_en = 1'b0;

    // random phase with a bench model, immediate timeout
    go_active();
    begin
      int ms = 0;   // 0 active, 1 sref, 2 pdn, 4 wake
      int wc = 0;
      int bad = 0;
      idle_sel = 2'd0;
      for (int cyc = 0; cyc < 3000; cyc++) begin
        if (cyc % 150 == 0) begin
          lp_mode = 2'($urandom % 3);
          exit_dly = 4'($urandom % 4);
        end
        acc_req = ($urandom % 4) == 0;
        xfer_busy = ($urandom % 3) == 0;
        #1;
        if (acc_wait != (acc_req && ms != 0)) bad++;
        case (ms)
          0: if (!acc_req && !xfer_busy && entry_code(lp_mode) != 0) ms = entry_code(lp_mode);
          1: if (acc_req) begin ms = 4; wc = int'(exit_dly); end
          2: if (acc_req) begin ms = 4; wc = 1; end
          default: if (wc == 0) ms = 0; else wc--;
        endcase
        tick();
        if (sd_cke != (ms == 0 || ms == 4)) bad++;
        if (sd_clk_en != (ms != 1)) bad++;
      end
      chk("R6", "random model mismatches", bad, 0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule